// File: doc/BRIEF.md
# Multi-channel down-counting timer unit

The block holds several identical 32-bit timer channels behind a small memory-mapped register port. Each channel counts down at a rate set by its own prescaler, which divides the peripheral clock by 4, 16, 64, 256 or 1024. When a count clock arrives while the counter holds zero, the counter reloads from the channel's constant register, a sticky underflow flag is set, and the channel's interrupt line goes high if its interrupt enable is set. Writing the same period into both the constant and the counter therefore gives a periodic tick. Software that needs an up-counting time base inverts all 32 bits of the counter value.

One shared run register holds one bit per channel. Software normally changes it by read-modify-write, so rewriting a bit that is already set leaves that channel's counting phase unchanged. Clearing a bit stops the channel and resets its prescaler. The register port takes one write per cycle. Read data is a combinational decode of the address and does not depend on the select strobe.

Top module: `countdown_timer_unit`

## Requirements
- R1: After reset, every constant and counter register reads 0xFFFFFFFF, every control register reads 0, the run register reads 0 and all interrupt lines are low.
- R2: Byte address 4 is the run register, with bit n belonging to channel n. Channel n owns the byte addresses 8+12n (constant), 12+12n (counter) and 16+12n (control). Any other address reads 0. Unused bits of the control and run registers read 0.
- R3: While its run bit is clear, a channel's counter holds its value. While the bit is set, the counter drops by one on each count clock. Channels count independently of each other.
- R4: Control bits [2:0] select the count clock. Codes 0, 1, 2, 3 and 4 give one decrement every 4, 16, 64, 256 and 1024 peripheral clocks. The first decrement lands on the Nth clock edge after the edge that sets the run bit.
- R5: A count clock that arrives while the counter is 0 loads the constant value and sets the underflow flag (control bit 8), both on the same edge.
- R6: Writing 0 to control bit 8 clears the flag, and writing 1 leaves it unchanged. If an underflow and a clearing write fall on the same edge, the flag ends up set.
- R7: A channel's interrupt line is high exactly when both its underflow flag and its interrupt enable (control bit 5) are set.
- R8: Rewriting the run register with a running channel's bit still set does not shift that channel's decrement times. Clearing the bit resets the prescaler, so after a restart the first decrement again comes a full ratio later.
- R9: A bus write to a counter register takes effect even when a count clock falls on the same edge.
- R10: Prescaler codes 5, 6 and 7 behave like code 4 (divide by 1024).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable, qualified by bus_sel_i |
| bus_addr_i | input | ADDR_W (6) | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| irq_o | output | NUM_CH (3) | Per-channel underflow interrupt |

## Verification
A prescaler with the wrong phase or the wrong ratio shows up as a counter decrement one or more cycles early or late. The bench looks at the counter on the cycle just before the expected decrement edge and again just after it, so a fault shows up within one count period. A flag that is wrong or left set reaches irq_o in the same cycle. A reload from the wrong source appears in the counter value read on the cycle after the underflow edge. The bench places writes on exact tick edges to expose errors in the priority between bus writes and hardware updates.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned NUM_RATIOS = 5;
  localparam int unsigned FLAG_BIT   = 8;
  localparam int unsigned IE_BIT     = 5;
  localparam int unsigned START_OFS  = 4;
  localparam int unsigned WIN_BASE   = 8;
  localparam int unsigned WIN_STRIDE = 12;

  typedef enum int unsigned {
    REG_CONST = 0,
    REG_COUNT = 1,
    REG_CTRL  = 2
  } chan_reg_e;

  function automatic int unsigned win_addr(int unsigned ch, chan_reg_e r);
    return WIN_BASE + WIN_STRIDE * ch + 4 * int'(r);
  endfunction
endpackage

// File: rtl/tmu_prescaler.sv
module tmu_prescaler
  import tmu_pkg::*;
#(
  parameter int unsigned N_RATIOS = NUM_RATIOS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PW   = 2 * N_RATIOS;
  localparam int unsigned NSEL = 1 << SEL_W;

  logic [PW-1:0]   pcnt_q;
  logic [NSEL-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (!run_i) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

  // ratio 4^(k+1): low 2(k+1) bits all ones; codes past the table use the slowest
  for (genvar k = 0; k < NSEL; k++) begin : g_hit
    if (k < N_RATIOS) begin : g_real
      assign hit[k] = &pcnt_q[2*k+1:0];
    end else begin : g_clamp
      assign hit[k] = &pcnt_q;
    end
  end

  assign tick_o = run_i & hit[sel_i];
endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
  import tmu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_const_i,
  input  logic              wr_count_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] const_o,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              uflow_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] const_q, count_q;
  logic [SEL_W-1:0]  sel_q;
  logic              ie_q, flag_q, tick;

  tmu_prescaler #(.N_RATIOS(NUM_RATIOS)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .sel_i (sel_q),
    .tick_o(tick)
  );

  assign uflow_o = tick && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      const_q <= '1;
      count_q <= '1;
      sel_q   <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_const_i) const_q <= wdata_i;
      if (wr_count_i)   count_q <= wdata_i;
      else if (uflow_o) count_q <= const_q;
      else if (tick)    count_q <= count_q - 1'b1;
      if (wr_ctrl_i) begin
        sel_q <= wdata_i[SEL_W-1:0];
        ie_q  <= wdata_i[IE_BIT];
      end
      if (uflow_o) flag_q <= 1'b1;
      else if (wr_ctrl_i && !wdata_i[FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o              = '0;
    ctrl_o[SEL_W-1:0]   = sel_q;
    ctrl_o[IE_BIT]      = ie_q;
    ctrl_o[FLAG_BIT]    = flag_q;
  end

  assign const_o = const_q;
  assign count_o = count_q;
  assign irq_o   = flag_q & ie_q;
endmodule

// File: rtl/countdown_timer_unit.sv
module countdown_timer_unit
  import tmu_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(START_OFS);

  logic                           wr_en, wr_start;
  logic [NUM_CH-1:0]              run_q;
  logic [NUM_CH-1:0]              wr_count_all, uflow_all;
  logic [NUM_CH-1:0][DATA_W-1:0]  const_all, count_all, ctrl_all;

  assign wr_en    = bus_sel_i & bus_we_i;
  assign wr_start = wr_en && (bus_addr_i == START_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (wr_start) run_q <= bus_wdata_i[NUM_CH-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(win_addr(n, REG_CONST));
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(win_addr(n, REG_COUNT));
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(win_addr(n, REG_CTRL));
    logic wr_const, wr_ctrl;

    assign wr_const        = wr_en && (bus_addr_i == A_CONST);
    assign wr_count_all[n] = wr_en && (bus_addr_i == A_COUNT);
    assign wr_ctrl         = wr_en && (bus_addr_i == A_CTRL);

    tmu_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_q[n]),
      .wr_const_i(wr_const),
      .wr_count_i(wr_count_all[n]),
      .wr_ctrl_i (wr_ctrl),
      .wdata_i   (bus_wdata_i),
      .const_o   (const_all[n]),
      .count_o   (count_all[n]),
      .ctrl_o    (ctrl_all[n]),
      .uflow_o   (uflow_all[n]),
      .irq_o     (irq_o[n])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == START_ADDR) bus_rdata_o[NUM_CH-1:0] = run_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr_i == ADDR_W'(win_addr(n, REG_CONST))) bus_rdata_o = const_all[n];
      if (bus_addr_i == ADDR_W'(win_addr(n, REG_COUNT))) bus_rdata_o = count_all[n];
      if (bus_addr_i == ADDR_W'(win_addr(n, REG_CTRL)))  bus_rdata_o = ctrl_all[n];
    end
  end
endmodule

// File: rtl/tmu_checks.sv
module tmu_checks
  import tmu_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CH-1:0]             run_q,
  input logic [NUM_CH-1:0]             wr_count_all,
  input logic [NUM_CH-1:0]             uflow_all,
  input logic [NUM_CH-1:0][DATA_W-1:0] const_all,
  input logic [NUM_CH-1:0][DATA_W-1:0] count_all,
  input logic [NUM_CH-1:0][DATA_W-1:0] ctrl_all,
  input logic [NUM_CH-1:0]             irq_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    assert_hold_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q[n] && !wr_count_all[n]) |=> $stable(count_all[n]));

    assert_step_by_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_count_all[n] && count_all[n] != '0) |=>
        (count_all[n] == $past(count_all[n]) || count_all[n] == $past(count_all[n]) - 1'b1));

    assert_reload_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_count_all[n] && count_all[n] == '0) |=>
        (count_all[n] == '0 || count_all[n] == $past(const_all[n])));

    assert_flag_from_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctrl_all[n][FLAG_BIT]) |-> $past(count_all[n]) == '0);

    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uflow_all[n] |=> ctrl_all[n][FLAG_BIT]);

    assert_irq_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] |-> (ctrl_all[n][IE_BIT] && ctrl_all[n][FLAG_BIT]));
  end
endmodule

bind countdown_timer_unit tmu_checks #(.NUM_CH(NUM_CH)) u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_q       (run_q),
  .wr_count_all(wr_count_all),
  .uflow_all   (uflow_all),
  .const_all   (const_all),
  .count_all   (count_all),
  .ctrl_all    (ctrl_all),
  .irq_o       (irq_o)
);

// File: tb/countdown_timer_unit_test.sv
`timescale 1ns/1ps
module countdown_timer_unit_test;
  localparam int NCH = 3;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NCH-1:0] irq;
  int total = 0, bad = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  countdown_timer_unit #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] a_const(int n); return AW'(8 + 12*n);  endfunction
  function automatic logic [AW-1:0] a_cnt(int n);   return AW'(12 + 12*n); endfunction
  function automatic logic [AW-1:0] a_ctrl(int n);  return AW'(16 + 12*n); endfunction
  localparam logic [AW-1:0] A_RUN = AW'(4);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #2 d = rdata;
  endtask

  task automatic t_reset;
    for (int n = 0; n < NCH; n++) begin
      rd(a_const(n), v); chk("R1 const", v, 32'hFFFF_FFFF);
      rd(a_cnt(n), v);   chk("R1 count", v, 32'hFFFF_FFFF);
      rd(a_ctrl(n), v);  chk("R1 ctrl", v, 32'h0);
    end
    rd(A_RUN, v); chk("R1 run", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_map;
    for (int n = 0; n < NCH; n++) begin
      wr(a_const(n), 32'h1000 + n);
      wr(a_cnt(n), 32'h2000 + n);
    end
    for (int n = 0; n < NCH; n++) begin
      rd(a_const(n), v); chk("R2 const window", v, 32'h1000 + n);
      rd(a_cnt(n), v);   chk("R2 count window", v, 32'h2000 + n);
    end
    wr(a_ctrl(0), 32'hFFFF_FFFF);
    rd(a_ctrl(0), v); chk("R2 ctrl mask", v, 32'h27);
    wr(a_ctrl(0), 32'h0);
    wr(A_RUN, 32'hFFFF_FFF8);
    rd(A_RUN, v); chk("R2 run mask", v, 32'h0);
    rd(AW'(0), v);  chk("R2 unmapped 0", v, 32'h0);
    rd(AW'(44), v); chk("R2 unmapped 44", v, 32'h0);
  endtask

  task automatic t_run_hold;
    wr(a_ctrl(0), 32'h0); wr(a_cnt(0), 32'd20);
    wr(a_cnt(1), 32'd30);
    wr(A_RUN, 32'h1);
    repeat (12) @(posedge clk);
    rd(a_cnt(0), v); chk("R3 ch0 three steps", v, 32'd17);
    rd(a_cnt(1), v); chk("R3 ch1 stopped holds", v, 32'd30);
    wr(A_RUN, 32'h0);
    rd(a_cnt(0), v);
    begin
      logic [31:0] held = v;
      repeat (20) @(posedge clk);
      rd(a_cnt(0), v); chk("R3 hold after stop", v, held);
    end
  endtask

  task automatic ratio_case(int code, int ratio, string tag);
    wr(A_RUN, 32'h0);
    wr(a_ctrl(2), 32'(code));
    wr(a_cnt(2), 32'd100);
    wr(A_RUN, 32'h4);
    repeat (ratio - 1) @(posedge clk);
    rd(a_cnt(2), v); chk({tag, " before edge"}, v, 32'd100);
    @(posedge clk);
    rd(a_cnt(2), v); chk({tag, " at edge"}, v, 32'd99);
  endtask

  task automatic t_ratios;
    ratio_case(0, 4, "R4 code0");
    ratio_case(1, 16, "R4 code1");
    ratio_case(2, 64, "R4 code2");
    ratio_case(3, 256, "R4 code3");
    ratio_case(4, 1024, "R4 code4");
    ratio_case(5, 1024, "R10 code5");
    ratio_case(7, 1024, "R10 code7");
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_underflow;
    wr(a_ctrl(1), 32'h20); wr(a_const(1), 32'd2); wr(a_cnt(1), 32'd1);
    wr(A_RUN, 32'h2);
    repeat (7) @(posedge clk);
    rd(a_cnt(1), v);  chk("R5 count at zero", v, 32'd0);
    rd(a_ctrl(1), v); chk("R5 flag not yet", v, 32'h20);
    chk("R7 irq low before", 32'(irq[1]), 32'd0);
    @(posedge clk);
    rd(a_cnt(1), v);  chk("R5 reload", v, 32'd2);
    rd(a_ctrl(1), v); chk("R5 flag set", v, 32'h120);
    chk("R7 irq high", 32'(irq[1]), 32'd1);
    wr(a_ctrl(1), 32'h100);
    rd(a_ctrl(1), v); chk("R6 write 1 keeps flag", v, 32'h100);
    chk("R7 irq masked", 32'(irq[1]), 32'd0);
    wr(a_ctrl(1), 32'h120);
    chk("R7 irq unmasked", 32'(irq[1]), 32'd1);
    wr(a_ctrl(1), 32'h20);
    rd(a_ctrl(1), v); chk("R6 write 0 clears", v, 32'h20);
    chk("R7 irq after clear", 32'(irq[1]), 32'd0);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_set_wins;
    wr(a_ctrl(1), 32'h0); wr(a_const(1), 32'd0); wr(a_cnt(1), 32'd0);
    wr(A_RUN, 32'h2);
    repeat (4) @(posedge clk);
    wr(a_ctrl(1), 32'h0);
    rd(a_ctrl(1), v); chk("R6 cleared off tick", v, 32'h0);
    repeat (2) @(posedge clk);
    wr(a_ctrl(1), 32'h0);
    rd(a_ctrl(1), v); chk("R6 set wins over clear", v, 32'h100);
    wr(a_ctrl(1), 32'h0);
    rd(a_ctrl(1), v); chk("R6 clear next cycle", v, 32'h0);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_run_rewrite;
    wr(a_ctrl(0), 32'h1); wr(a_cnt(0), 32'd200);
    wr(A_RUN, 32'h1);
    repeat (4) @(posedge clk);
    wr(A_RUN, 32'h5);
    repeat (10) @(posedge clk);
    rd(a_cnt(0), v); chk("R8 rewrite keeps phase (before)", v, 32'd200);
    @(posedge clk);
    rd(a_cnt(0), v); chk("R8 rewrite keeps phase (edge)", v, 32'd199);
    wr(A_RUN, 32'h4);
    repeat (40) @(posedge clk);
    rd(a_cnt(0), v); chk("R8 stopped holds", v, 32'd199);
    wr(A_RUN, 32'h5);
    repeat (15) @(posedge clk);
    rd(a_cnt(0), v); chk("R8 restart full ratio (before)", v, 32'd199);
    @(posedge clk);
    rd(a_cnt(0), v); chk("R8 restart full ratio (edge)", v, 32'd198);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_write_priority;
    wr(a_ctrl(0), 32'h0); wr(a_cnt(0), 32'd10);
    wr(A_RUN, 32'h1);
    repeat (7) @(posedge clk);
    wr(a_cnt(0), 32'd50);
    rd(a_cnt(0), v); chk("R9 write beats tick", v, 32'd50);
    repeat (3) @(posedge clk);
    rd(a_cnt(0), v); chk("R9 holds until next tick", v, 32'd50);
    @(posedge clk);
    rd(a_cnt(0), v); chk("R9 next tick", v, 32'd49);
    wr(A_RUN, 32'h0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_map;
    t_run_hold;
    t_ratios;
    t_underflow;
    t_set_wins;
    t_run_rewrite;
    t_write_priority;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule